// File: doc/BRIEF.md
# Store-Through Merge and SECDED Word Builder

This block sits beside the data array of a first-level cache that keeps stores locally and also forwards each one to the next cache level at once. A store arrives with one 16-byte array row index, the store data and a byte mask. The block reads the addressed row from the local array. It writes only the changed bytes back, with freshly computed byte parity. It then fills the unchanged bytes of the row from the local copy, computes SECDED check bits over each 64-bit half, and places the whole protected row on a 16-byte store bus. Because the row is always complete, the next level only has to compute its own code and write, with no read of its own.

The local array holds one even-parity bit per byte, so a byte is the smallest unit ever written and no merge inside a byte is needed. A parity error is handled by invalidating the line, not by correcting it. A parity error can come from an unchanged byte of the row or from the directory lookup of the store. In that case the block asks for the line to be invalidated and sends the store on as a partial store. A store that misses the local cache is also sent on as a partial store. A partial store carries only its changed bytes and a flag asking the next level to merge them itself. The store bus is shared with fetch-return traffic, and fetch data always takes priority over a waiting store.

Top module: `stm_store_merge`

## Requirements
- R1: After reset, `sb_valid`, `inv_valid` and `arr_wr_en` are low and `st_ready` is high.
- R2: A store that hits with no parity error writes the array once. The write uses `arr_wr_be` equal to the store mask and the store data. Each `arr_wr_par[b]` is the XOR of data byte b (even parity). Afterwards the array row holds the new bytes where the mask is set and the old bytes and old parity elsewhere.
- R3: For such a clean hit, the bus beat carries the merged row, with store bytes where the mask is set and local array bytes elsewhere, `sb_be` all ones, `sb_rmw` low and `sb_idx` equal to the store index.
- R4: `sb_ecc[8l+7:8l]` is the SECDED code of `sb_data[64l+63:64l]`. Data bit i sits at the i-th position in 1..71 that is not a power of two. Check bit k (0..6) is the XOR of the data bits whose position has bit k set. Check bit 7 is the XOR of all data bits and check bits 0..6.
- R5: A store that misses (with no directory parity error) does not write the array and raises no invalidation. It is sent with `sb_rmw` high, `sb_be` equal to the mask, and zero in every unmasked byte.
- R6: If a hit finds a parity mismatch in any unmasked byte of the row read, `inv_valid` pulses for one cycle with `inv_line` equal to `st_idx >> BEAT_W`. The array is not written, and the store is sent as in R5.
- R7: A store flagged with a directory parity error is handled as in R6, whether or not it hits.
- R8: A parity mismatch confined to bytes the store overwrites causes no invalidation. The write repairs their parity.
- R9: While `fetch_own` is high, `sb_valid` stays low and the pending beat is held. The beat appears for exactly one cycle, in the first cycle in which `fetch_own` is low.
- R10: Only one store is in flight. `st_ready` drops in the cycle after a store is accepted and returns in the cycle after its beat is sent. The beat appears no earlier than two cycles after acceptance, the array write and invalidation pulse exactly two cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Block can accept a store |
| st_idx | input | IDX_W | Array row index of the store |
| st_data | input | 128 | Store data, byte b in bits 8b+7:8b |
| st_mask | input | 16 | Byte mask of changed bytes |
| st_hit | input | 1 | Directory found the line in the local cache |
| st_dir_perr | input | 1 | Directory lookup reported a parity error |
| arr_rd_en | output | 1 | Array read strobe (data returned next cycle) |
| arr_rd_idx | output | IDX_W | Array read row |
| arr_rd_data | input | 128 | Array read data |
| arr_rd_par | input | 16 | Array read byte parity |
| arr_wr_en | output | 1 | Array write strobe |
| arr_wr_idx | output | IDX_W | Array write row |
| arr_wr_be | output | 16 | Array byte write enables |
| arr_wr_data | output | 128 | Array write data |
| arr_wr_par | output | 16 | Array write byte parity |
| fetch_own | input | 1 | Fetch-return data owns the store bus this cycle |
| sb_valid | output | 1 | Store bus beat valid |
| sb_idx | output | IDX_W | Row index of the beat |
| sb_data | output | 128 | Beat data, two 64-bit ECC words |
| sb_ecc | output | 16 | Check bits, 8 per 64-bit word |
| sb_be | output | 16 | Byte enables of the beat |
| sb_rmw | output | 1 | Partial store: next level must merge |
| inv_valid | output | 1 | Invalidate request for a local line |
| inv_line | output | IDX_W-BEAT_W | Line to invalidate |

## Verification
Some properties are checked on every cycle. These are the per-byte parity of every array write and the all-ones enables of a full beat. Others are the zero unmasked bytes of a partial beat and the exclusion between invalidation and array write. The rest are the bus being withheld while fetch data owns it, the single-cycle beat and the drop of `st_ready` after acceptance. The bench scenarios show what needs the array contents: the merged row, the check bits against an independent code model, and the repaired array row. They also show which parity errors invalidate and which are ignored because the byte is overwritten. Finally, they show how the beat timing shifts under fetch occupancy.

// File: rtl/stm_pkg.sv
package stm_pkg;
  localparam int WORD_BYTES = 8;
  localparam int WORD_BITS  = WORD_BYTES * 8;
  localparam int CHK_BITS   = 8;
  localparam int CODE_LEN   = WORD_BITS + CHK_BITS - 1;

  // Hamming check bits over a 64-bit word plus an overall parity bit.
  function automatic logic [CHK_BITS-1:0] secded_code(input logic [WORD_BITS-1:0] d);
    logic [CHK_BITS-1:0] c;
    int di;
    c  = '0;
    di = 0;
    for (int p = 1; p <= CODE_LEN; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int k = 0; k < CHK_BITS - 1; k++) begin
          if (p[k]) c[k] = c[k] ^ d[di[5:0]];
        end
        di++;
      end
    end
    c[CHK_BITS-1] = (^d) ^ (^c[CHK_BITS-2:0]);
    return c;
  endfunction
endpackage

// File: rtl/stm_ecc_gen.sv
module stm_ecc_gen
  import stm_pkg::*;
(
  input  logic [WORD_BITS-1:0] data,
  output logic [CHK_BITS-1:0]  chk
);
  always_comb chk = secded_code(data);
endmodule

// File: rtl/stm_lane_merge.sv
module stm_lane_merge #(
  parameter int NBYTES = 8
) (
  input  logic [NBYTES*8-1:0] old_d,
  input  logic [NBYTES-1:0]   old_p,
  input  logic [NBYTES*8-1:0] new_d,
  input  logic [NBYTES-1:0]   mask,
  output logic [NBYTES*8-1:0] merged,
  output logic [NBYTES*8-1:0] masked,
  output logic [NBYTES-1:0]   new_p,
  output logic                perr
);
  logic [NBYTES-1:0] bad;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign merged[b*8 +: 8] = mask[b] ? new_d[b*8 +: 8] : old_d[b*8 +: 8];
    assign masked[b*8 +: 8] = mask[b] ? new_d[b*8 +: 8] : 8'h00;
    assign new_p[b]         = ^new_d[b*8 +: 8];
    // only bytes that survive into the merged word are checked
    assign bad[b]           = !mask[b] && ((^old_d[b*8 +: 8]) != old_p[b]);
  end

  assign perr = |bad;
endmodule

// File: rtl/stm_store_merge.sv
module stm_store_merge
  import stm_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int IDX_W  = 10,
  parameter int BEAT_W = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           st_valid,
  output logic                           st_ready,
  input  logic [IDX_W-1:0]               st_idx,
  input  logic [LANES*WORD_BITS-1:0]     st_data,
  input  logic [LANES*WORD_BYTES-1:0]    st_mask,
  input  logic                           st_hit,
  input  logic                           st_dir_perr,
  output logic                           arr_rd_en,
  output logic [IDX_W-1:0]               arr_rd_idx,
  input  logic [LANES*WORD_BITS-1:0]     arr_rd_data,
  input  logic [LANES*WORD_BYTES-1:0]    arr_rd_par,
  output logic                           arr_wr_en,
  output logic [IDX_W-1:0]               arr_wr_idx,
  output logic [LANES*WORD_BYTES-1:0]    arr_wr_be,
  output logic [LANES*WORD_BITS-1:0]     arr_wr_data,
  output logic [LANES*WORD_BYTES-1:0]    arr_wr_par,
  input  logic                           fetch_own,
  output logic                           sb_valid,
  output logic [IDX_W-1:0]               sb_idx,
  output logic [LANES*WORD_BITS-1:0]     sb_data,
  output logic [LANES*CHK_BITS-1:0]      sb_ecc,
  output logic [LANES*WORD_BYTES-1:0]    sb_be,
  output logic                           sb_rmw,
  output logic                           inv_valid,
  output logic [IDX_W-BEAT_W-1:0]        inv_line
);
  localparam int BYTES  = LANES * WORD_BYTES;
  localparam int DW     = LANES * WORD_BITS;
  localparam int CW     = LANES * CHK_BITS;
  localparam int LINE_W = IDX_W - BEAT_W;

  // merge stage registers (one cycle after acceptance)
  logic             b_valid_q;
  logic [IDX_W-1:0] b_idx_q;
  logic [DW-1:0]    b_data_q;
  logic [BYTES-1:0] b_mask_q;
  logic             b_hit_q;
  logic             b_dperr_q;

  // output registers
  logic             pend_q;
  logic             wr_en_q;
  logic             inv_q;
  logic [IDX_W-1:0] sb_idx_q;
  logic [DW-1:0]    sb_data_q;
  logic [CW-1:0]    sb_ecc_q;
  logic [BYTES-1:0] sb_be_q;
  logic             sb_rmw_q;
  logic [IDX_W-1:0] wr_idx_q;
  logic [BYTES-1:0] wr_be_q;
  logic [DW-1:0]    wr_data_q;
  logic [BYTES-1:0] wr_par_q;
  logic [LINE_W-1:0] inv_line_q;

  logic accept;
  assign st_ready   = !b_valid_q && !pend_q;
  assign accept     = st_valid && st_ready;
  assign arr_rd_en  = accept;
  assign arr_rd_idx = st_idx;

  // per-lane merge and code generation
  logic [DW-1:0]    merged_w, masked_w, out_w;
  logic [BYTES-1:0] newp_w;
  logic [LANES-1:0] lane_perr;
  logic [CW-1:0]    ecc_w;
  logic             inv_n, rmw_n, wr_n;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    stm_lane_merge #(.NBYTES(WORD_BYTES)) u_merge (
      .old_d  (arr_rd_data[l*WORD_BITS +: WORD_BITS]),
      .old_p  (arr_rd_par[l*WORD_BYTES +: WORD_BYTES]),
      .new_d  (b_data_q[l*WORD_BITS +: WORD_BITS]),
      .mask   (b_mask_q[l*WORD_BYTES +: WORD_BYTES]),
      .merged (merged_w[l*WORD_BITS +: WORD_BITS]),
      .masked (masked_w[l*WORD_BITS +: WORD_BITS]),
      .new_p  (newp_w[l*WORD_BYTES +: WORD_BYTES]),
      .perr   (lane_perr[l])
    );
    stm_ecc_gen u_ecc (
      .data (out_w[l*WORD_BITS +: WORD_BITS]),
      .chk  (ecc_w[l*CHK_BITS +: CHK_BITS])
    );
  end

  always_comb begin
    inv_n = b_dperr_q || (b_hit_q && (|lane_perr));
    rmw_n = !b_hit_q || inv_n;
    wr_n  = b_hit_q && !inv_n;
    out_w = rmw_n ? masked_w : merged_w;
  end

  // control state, reset
  always_ff @(posedge clk) begin
    if (rst) begin
      b_valid_q <= 1'b0;
      pend_q    <= 1'b0;
      wr_en_q   <= 1'b0;
      inv_q     <= 1'b0;
    end else begin
      b_valid_q <= accept;
      wr_en_q   <= b_valid_q && wr_n;
      inv_q     <= b_valid_q && inv_n;
      if (b_valid_q)
        pend_q <= 1'b1;
      else if (pend_q && !fetch_own)
        pend_q <= 1'b0;
    end
  end

  // datapath registers, no reset
  always_ff @(posedge clk) begin
    if (accept) begin
      b_idx_q   <= st_idx;
      b_data_q  <= st_data;
      b_mask_q  <= st_mask;
      b_hit_q   <= st_hit;
      b_dperr_q <= st_dir_perr;
    end
    if (b_valid_q) begin
      sb_idx_q   <= b_idx_q;
      sb_data_q  <= out_w;
      sb_ecc_q   <= ecc_w;
      sb_be_q    <= rmw_n ? b_mask_q : {BYTES{1'b1}};
      sb_rmw_q   <= rmw_n;
      wr_idx_q   <= b_idx_q;
      wr_be_q    <= b_mask_q;
      wr_data_q  <= b_data_q;
      wr_par_q   <= newp_w;
      inv_line_q <= b_idx_q[IDX_W-1:BEAT_W];
    end
  end

  assign sb_valid    = pend_q && !fetch_own;
  assign sb_idx      = sb_idx_q;
  assign sb_data     = sb_data_q;
  assign sb_ecc      = sb_ecc_q;
  assign sb_be       = sb_be_q;
  assign sb_rmw      = sb_rmw_q;
  assign arr_wr_en   = wr_en_q;
  assign arr_wr_idx  = wr_idx_q;
  assign arr_wr_be   = wr_be_q;
  assign arr_wr_data = wr_data_q;
  assign arr_wr_par  = wr_par_q;
  assign inv_valid   = inv_q;
  assign inv_line    = inv_line_q;
endmodule

// File: rtl/stm_store_merge_chk.sv
module stm_store_merge_chk #(
  parameter int BYTES = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               st_valid,
  input logic               st_ready,
  input logic               fetch_own,
  input logic               sb_valid,
  input logic [BYTES*8-1:0] sb_data,
  input logic [BYTES-1:0]   sb_be,
  input logic               sb_rmw,
  input logic               arr_wr_en,
  input logic [BYTES-1:0]   arr_wr_be,
  input logic [BYTES*8-1:0] arr_wr_data,
  input logic [BYTES-1:0]   arr_wr_par,
  input logic               inv_valid
);
  logic par_ok, zero_ok;

  always_comb begin
    par_ok  = 1'b1;
    zero_ok = 1'b1;
    for (int b = 0; b < BYTES; b++) begin
      if (arr_wr_be[b] && (arr_wr_par[b] != ^arr_wr_data[b*8 +: 8])) par_ok = 1'b0;
      if (!sb_be[b] && (sb_data[b*8 +: 8] != 8'h00)) zero_ok = 1'b0;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!sb_valid && !inv_valid && !arr_wr_en && st_ready));

  assert_write_parity_R2: assert property (@(posedge clk) disable iff (rst)
    arr_wr_en |-> par_ok);

  assert_write_full_beat_R2: assert property (@(posedge clk) disable iff (rst)
    (arr_wr_en && !fetch_own) |-> (sb_valid && !sb_rmw));

  assert_full_enables_R3: assert property (@(posedge clk) disable iff (rst)
    (sb_valid && !sb_rmw) |-> (&sb_be));

  assert_partial_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (sb_valid && sb_rmw) |-> zero_ok);

  assert_inv_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> !arr_wr_en);

  assert_inv_partial_R7: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && !fetch_own) |-> (sb_valid && sb_rmw));

  assert_fetch_wins_R9: assert property (@(posedge clk) disable iff (rst)
    fetch_own |-> !sb_valid);

  assert_single_beat_R9: assert property (@(posedge clk) disable iff (rst)
    sb_valid |=> !sb_valid);

  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
    (st_valid && st_ready) |=> !st_ready);
endmodule

bind stm_store_merge stm_store_merge_chk #(.BYTES(LANES*8)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .st_valid    (st_valid),
  .st_ready    (st_ready),
  .fetch_own   (fetch_own),
  .sb_valid    (sb_valid),
  .sb_data     (sb_data),
  .sb_be       (sb_be),
  .sb_rmw      (sb_rmw),
  .arr_wr_en   (arr_wr_en),
  .arr_wr_be   (arr_wr_be),
  .arr_wr_data (arr_wr_data),
  .arr_wr_par  (arr_wr_par),
  .inv_valid   (inv_valid)
);

// File: tb/test_stm_store_merge.sv
`timescale 1ns/1ps
module test_stm_store_merge;
  localparam int IW    = 10;
  localparam int BW    = 4;
  localparam int DEPTH = 1 << IW;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         st_valid = 1'b0;
  logic         st_ready;
  logic [IW-1:0] st_idx = '0;
  logic [127:0] st_data = '0;
  logic [15:0]  st_mask = '0;
  logic         st_hit = 1'b0;
  logic         st_dir_perr = 1'b0;
  logic         arr_rd_en;
  logic [IW-1:0] arr_rd_idx;
  logic [127:0] arr_rd_data;
  logic [15:0]  arr_rd_par;
  logic         arr_wr_en;
  logic [IW-1:0] arr_wr_idx;
  logic [15:0]  arr_wr_be;
  logic [127:0] arr_wr_data;
  logic [15:0]  arr_wr_par;
  logic         fetch_own = 1'b0;
  logic         sb_valid;
  logic [IW-1:0] sb_idx;
  logic [127:0] sb_data;
  logic [15:0]  sb_ecc;
  logic [15:0]  sb_be;
  logic         sb_rmw;
  logic         inv_valid;
  logic [IW-BW-1:0] inv_line;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  stm_store_merge #(.LANES(2), .IDX_W(IW), .BEAT_W(BW)) i_stm_store_merge (.*);

  // array model: one-cycle read latency, byte write enables
  logic [127:0] mem_d [DEPTH];
  logic [15:0]  mem_p [DEPTH];
  logic [127:0] rd_d_q;
  logic [15:0]  rd_p_q;
  assign arr_rd_data = rd_d_q;
  assign arr_rd_par  = rd_p_q;

  always @(posedge clk) begin
    if (arr_rd_en) begin
      rd_d_q <= mem_d[arr_rd_idx];
      rd_p_q <= mem_p[arr_rd_idx];
    end
    if (arr_wr_en) begin
      for (int b = 0; b < 16; b++) begin
        if (arr_wr_be[b]) begin
          mem_d[arr_wr_idx][b*8 +: 8] <= arr_wr_data[b*8 +: 8];
          mem_p[arr_wr_idx][b]        <= arr_wr_par[b];
        end
      end
    end
  end

  function automatic logic [15:0] byte_par(input logic [127:0] d);
    logic [15:0] p;
    for (int b = 0; b < 16; b++) p[b] = ^d[b*8 +: 8];
    return p;
  endfunction

  function automatic logic [7:0] ecc_ref(input logic [63:0] d);
    logic [71:0] cw;
    logic [7:0]  c;
    int j;
    cw = '0;
    j  = 0;
    for (int pos = 1; pos < 72; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        cw[pos] = d[j];
        j++;
      end
    end
    c = '0;
    for (int k = 0; k < 7; k++)
      for (int pos = 1; pos < 72; pos++)
        if (((pos >> k) & 1) == 1) c[k] = c[k] ^ cw[pos];
    c[7] = (^d) ^ (^c[6:0]);
    return c;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_store(input logic [IW-1:0] idx, input logic [127:0] d, input logic [15:0] m,
                           input bit hit, input bit dirp, input int fh);
    logic [127:0] old_d, mrg, msk, exp_sb, exp_mem;
    logic [15:0]  old_p, exp_be, exp_memp;
    bit perr_u, e_inv, e_rmw, e_wr;
    int exp_n;
    old_d  = mem_d[idx];
    old_p  = mem_p[idx];
    perr_u = 1'b0;
    for (int b = 0; b < 16; b++) begin
      mrg[b*8 +: 8] = m[b] ? d[b*8 +: 8] : old_d[b*8 +: 8];
      msk[b*8 +: 8] = m[b] ? d[b*8 +: 8] : 8'h00;
      if (!m[b] && ((^old_d[b*8 +: 8]) != old_p[b])) perr_u = 1'b1;
    end
    e_inv    = dirp || (hit && perr_u);
    e_rmw    = !hit || e_inv;
    e_wr     = hit && !e_inv;
    exp_sb   = e_rmw ? msk : mrg;
    exp_be   = e_rmw ? m : 16'hFFFF;
    exp_mem  = e_wr ? mrg : old_d;
    exp_memp = old_p;
    if (e_wr) for (int b = 0; b < 16; b++) if (m[b]) exp_memp[b] = ^d[b*8 +: 8];
    exp_n = (fh + 1 > 2) ? fh + 1 : 2;

    @(negedge clk);
    st_idx = idx; st_data = d; st_mask = m; st_hit = hit; st_dir_perr = dirp; st_valid = 1'b1;
    #1;
    chk(st_ready, "R10 ready before store", {127'd0, st_ready}, 128'd1);
    @(negedge clk);
    st_valid = 1'b0;
    for (int n = 1; n <= exp_n + 1; n++) begin
      if (n > 1) @(negedge clk);
      fetch_own = (n <= fh);
      #1;
      if (n < exp_n) begin
        chk(!sb_valid, "R9 beat withheld", {127'd0, sb_valid}, 128'd0);
        chk(!st_ready, "R10 busy in flight", {127'd0, st_ready}, 128'd0);
      end
      if (n == 2) begin
        chk(arr_wr_en == e_wr, "R2 write strobe", {127'd0, arr_wr_en}, {127'd0, e_wr});
        if (e_wr) begin
          chk(arr_wr_be == m && arr_wr_idx == idx, "R2 write enables", {102'd0, arr_wr_idx, arr_wr_be}, {102'd0, idx, m});
          chk(arr_wr_par == byte_par(d), "R2 write parity", {112'd0, arr_wr_par}, {112'd0, byte_par(d)});
        end
        chk(inv_valid == e_inv, "R6 R7 invalidate", {127'd0, inv_valid}, {127'd0, e_inv});
        if (e_inv)
          chk(inv_line == idx[IW-1:BW], "R6 invalidate line", {122'd0, inv_line}, {122'd0, idx[IW-1:BW]});
      end
      if (n == 3)
        chk(!arr_wr_en && !inv_valid, "R6 single pulse", {126'd0, arr_wr_en, inv_valid}, 128'd0);
      if (n == exp_n) begin
        chk(sb_valid, "R9 R10 beat sent", {127'd0, sb_valid}, 128'd1);
        chk(sb_data == exp_sb, e_rmw ? "R5 partial data" : "R3 merged data", sb_data, exp_sb);
        chk(sb_be == exp_be && sb_rmw == e_rmw && sb_idx == idx, "R3 R5 enables/flag",
            {101'd0, sb_idx, sb_rmw, sb_be}, {101'd0, idx, e_rmw, exp_be});
        chk(sb_ecc == {ecc_ref(exp_sb[127:64]), ecc_ref(exp_sb[63:0])}, "R4 check bits",
            {112'd0, sb_ecc}, {112'd0, ecc_ref(exp_sb[127:64]), ecc_ref(exp_sb[63:0])});
      end
      if (n == exp_n + 1)
        chk(!sb_valid && st_ready, "R9 R10 one beat then ready", {126'd0, sb_valid, st_ready}, 128'd1);
    end
    fetch_own = 1'b0;
    chk(mem_d[idx] == exp_mem, "R2 R8 array row", mem_d[idx], exp_mem);
    chk(mem_p[idx] == exp_memp, "R2 R8 array parity", {112'd0, mem_p[idx]}, {112'd0, exp_memp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd24601));
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = rnd128();
      mem_p[i] = byte_par(mem_d[i]);
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!sb_valid && !inv_valid && !arr_wr_en && st_ready, "R1 reset state",
        {124'd0, sb_valid, inv_valid, arr_wr_en, st_ready}, 128'd1);

    // R3 full-mask hit and partial hit
    run_store(10'd5, rnd128(), 16'hFFFF, 1, 0, 0);
    run_store(10'd6, rnd128(), 16'h0F30, 1, 0, 0);
    // empty mask hit: row unchanged, full beat
    run_store(10'd7, rnd128(), 16'h0000, 1, 0, 0);
    // R5 miss
    run_store(10'd8, rnd128(), 16'h8001, 0, 0, 0);
    // R6 parity error in an unchanged byte
    mem_p[10'd40][3] = ~mem_p[10'd40][3];
    run_store(10'd40, rnd128(), 16'h00F0, 1, 0, 0);
    // R8 parity error only in an overwritten byte
    mem_p[10'd41][2] = ~mem_p[10'd41][2];
    run_store(10'd41, rnd128(), 16'h000C, 1, 0, 0);
    // R7 directory parity error, hit and miss
    run_store(10'd99, rnd128(), 16'h1234, 1, 1, 0);
    run_store(10'd100, rnd128(), 16'h00FF, 0, 1, 0);
    // R9 fetch occupies the bus for several cycles
    run_store(10'd200, rnd128(), 16'hF00F, 1, 0, 3);
    run_store(10'd201, rnd128(), 16'h0001, 0, 0, 5);

    for (int it = 0; it < 120; it++) begin
      logic [IW-1:0] idx;
      idx = IW'($urandom());
      if ($urandom() % 2 == 0) idx = IW'($urandom() % 16);
      if ($urandom() % 10 == 0) begin
        int bb;
        bb = $urandom() % 16;
        mem_p[idx][bb] = ~mem_p[idx][bb];
      end
      run_store(idx, rnd128(), 16'($urandom()), ($urandom() % 8) != 0,
                ($urandom() % 20) == 0, ($urandom() % 3 == 0) ? int'($urandom() % 5) : 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule